// File: doc/BRIEF.md
# Descriptor Ring Transmit/Receive Engine

This block moves Ethernet-style frames between a byte stream and host memory. Software places two circular lists of descriptors in memory, one for outgoing frames and one for incoming frames. The engine reaches that memory through a single synchronous, word-addressed port. Each descriptor takes three consecutive 32-bit words. The first word holds the flags. The second holds the lengths. The third holds the byte address of the data buffer.

Software owns a descriptor while its active flag is clear. The engine owns it while the flag is set, and it clears the flag when it has finished with the descriptor. Ring wrap is controlled by an end-of-list flag inside the descriptor itself. Transmission starts on a request pulse. The request stays raised until the engine reaches a descriptor that software has not handed over. Reception works the same way with an enable bit: the engine fills buffers from an incoming byte stream that carries end-of-frame and error markers.

Top module: `desc_ring_dma`

## Requirements
- R1: While reset is held and after it is released, `tx_busy`, `rx_on`, `mem_req`, `tx_valid` and `rx_ready` are all low.
- R2: A descriptor occupies three consecutive memory words. Word 0 holds the flags: bit 31 is active, bit 30 is end-of-list and bit 27 is error. Word 2 holds a byte address whose two low bits are ignored. After reset, each ring starts at its base input. The next descriptor is at the current one plus 3, or at the base when end-of-list was set.
- R3: For an owned transmit descriptor, the engine sends the number of bytes given in word 1 bits 31:16, read from the buffer. Byte 0 of each word is bits 7:0. `tx_last` marks the final byte. A length of zero sends nothing.
- R4: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` hold their values into the next cycle.
- R5: When a transmit descriptor finishes, the engine writes word 0 with active clear, end-of-list kept and all other bits zero. While the request is still set, it then moves on to the next descriptor.
- R6: When the engine fetches a descriptor whose active bit is clear, it writes nothing and drops `tx_busy` (transmit) or `rx_on` (receive). After the next `tx_go` or `rx_go` it resumes at that same descriptor.
- R7: A received frame is packed into buffer words with the first byte in bits 7:0. Unused bytes of the final word are written as zero. Word 1 is written back with the capacity kept in bits 31:16 and the stored length in bits 15:0. Word 0 is written with active clear and end-of-list kept.
- R8: If `rx_err` is high on any byte of a frame, bit 27 of that descriptor's word 0 is set when it is written back.
- R9: Bytes beyond the capacity in word 1 bits 31:16 are consumed up to `rx_last` but not stored. The stored length equals the capacity, and bit 27 of word 0 is set.
- R10: The cycle after `rx_stop`, `rx_on` is low. No new frame is accepted: `rx_ready` stays low and no descriptor changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_base | input | AW | Word address of the first transmit descriptor |
| rx_base | input | AW | Word address of the first receive descriptor |
| tx_go | input | 1 | Pulse: set the transmit request |
| rx_go | input | 1 | Pulse: set the receive enable |
| rx_stop | input | 1 | Pulse: clear the receive enable |
| tx_busy | output | 1 | Transmit request bit |
| rx_on | output | 1 | Receive enable bit |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| tx_valid | output | 1 | Transmit byte valid |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Final byte of the frame |
| tx_ready | input | 1 | Sink accepts the byte |
| rx_valid | input | 1 | Receive byte valid |
| rx_data | input | 8 | Receive byte |
| rx_last | input | 1 | Final byte of the frame |
| rx_err | input | 1 | Frame error marker |
| rx_ready | output | 1 | Engine accepts the byte |

## Verification
A wrong ring pointer shows up at once. The wrong buffer is sent, or the wrong word-0 address is written, within a dozen cycles of the descriptor fetch. A bad byte counter or lane select appears as a wrong or reordered byte on `tx_data`, or as a misplaced `tx_last`. A stale error or truncation flag, or a wrong length, becomes visible in the descriptor words a few cycles after `rx_last`. A missed ownership check either overwrites a software-owned descriptor or fails to drop `tx_busy`/`rx_on` two cycles after that descriptor's fetch.

// File: rtl/desc_ring_dma.sv
module desc_ring_dma #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] tx_base,
  input  logic [AW-1:0] rx_base,
  input  logic          tx_go,
  input  logic          rx_go,
  input  logic          rx_stop,
  output logic          tx_busy,
  output logic          rx_on,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  output logic          tx_valid,
  output logic [7:0]    tx_data,
  output logic          tx_last,
  input  logic          tx_ready,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  input  logic          rx_last,
  input  logic          rx_err,
  output logic          rx_ready
);
  localparam int ACT = 31;
  localparam int EOL = 30;
  localparam int ERR = 27;

  typedef enum logic [3:0] {IDLE, D0, D1, D2, D3, TRD, TLD, TSND, RXB, RXW, WB1, WB0} st_t;
  st_t st;

  logic [AW-1:0] tx_ptr, rx_ptr, buf_w, wa;
  logic          tx_fresh, rx_fresh, rxs, eol, err, fin;
  logic [15:0]   len, cnt;
  logic [31:0]   stage;

  wire [AW-1:0] tx_cur = tx_fresh ? tx_base : tx_ptr;
  wire [AW-1:0] rx_cur = rx_fresh ? rx_base : rx_ptr;
  wire [AW-1:0] cur    = rxs ? rx_cur : tx_cur;
  wire [AW-1:0] cnt_w  = AW'(cnt[15:2]);
  wire [1:0]    lane   = cnt[1:0];
  wire          room   = cnt < len;

  assign tx_valid = (st == TSND);
  assign tx_data  = stage[8*lane +: 8];
  assign tx_last  = tx_valid && (cnt + 16'd1 == len);
  assign rx_ready = (st == RXB);

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = cur;
    mem_wdata = '0;
    case (st)
      D0:  mem_req = 1'b1;
      D1:  begin mem_req = mem_rdata[ACT]; mem_addr = cur + AW'(1); end
      D2:  begin mem_req = 1'b1; mem_addr = cur + AW'(2); end
      TRD: begin mem_req = 1'b1; mem_addr = buf_w + cnt_w; end
      RXW: begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = wa; mem_wdata = stage; end
      WB1: begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = cur + AW'(1); mem_wdata = {len, cnt}; end
      WB0: begin mem_req = 1'b1; mem_we = 1'b1; mem_wdata = (32'(eol) << EOL) | (32'(err) << ERR); end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE;
      tx_busy <= 1'b0; rx_on <= 1'b0;
      tx_ptr <= '0; rx_ptr <= '0; tx_fresh <= 1'b1; rx_fresh <= 1'b1;
      buf_w <= '0; wa <= '0; rxs <= 1'b0; eol <= 1'b0; err <= 1'b0; fin <= 1'b0;
      len <= '0; cnt <= '0; stage <= '0;
    end else begin
      if (tx_go)   tx_busy <= 1'b1;
      if (rx_go)   rx_on   <= 1'b1;
      if (rx_stop) rx_on   <= 1'b0;
      case (st)
        IDLE:
          if (rx_on && rx_valid) begin rxs <= 1'b1; st <= D0; end
          else if (tx_busy)      begin rxs <= 1'b0; st <= D0; end
        D0: begin cnt <= '0; err <= 1'b0; fin <= 1'b0; stage <= '0; st <= D1; end
        D1:
          if (!mem_rdata[ACT]) begin
            if (rxs) rx_on <= 1'b0; else tx_busy <= 1'b0;
            st <= IDLE;
          end else begin
            eol <= mem_rdata[EOL];
            st  <= D2;
          end
        D2: begin len <= mem_rdata[31:16]; st <= D3; end
        D3: begin
          buf_w <= mem_rdata[AW+1:2];
          st <= rxs ? RXB : ((len == 16'd0) ? WB0 : TRD);
        end
        TRD: st <= TLD;
        TLD: begin stage <= mem_rdata; st <= TSND; end
        TSND:
          if (tx_ready) begin
            cnt <= cnt + 16'd1;
            if (cnt + 16'd1 == len) st <= WB0;
            else if (lane == 2'd3)  st <= TRD;
          end
        RXB:
          if (rx_valid) begin
            if (rx_err) err <= 1'b1;
            fin <= rx_last;
            wa  <= buf_w + cnt_w;
            if (room) begin
              stage[8*lane +: 8] <= rx_data;
              cnt <= cnt + 16'd1;
              if (lane == 2'd3 || rx_last) st <= RXW;
            end else begin
              err <= 1'b1;
              if (rx_last) st <= (lane != 2'd0) ? RXW : WB1;
            end
          end
        RXW: begin stage <= '0; st <= fin ? WB1 : RXB; end
        WB1: st <= WB0;
        WB0: begin
          if (rxs) begin rx_ptr <= eol ? rx_base : rx_cur + AW'(3); rx_fresh <= 1'b0; end
          else     begin tx_ptr <= eol ? tx_base : tx_cur + AW'(3); tx_fresh <= 1'b0; end
          st <= IDLE;
        end
        default: st <= IDLE;
      endcase
    end
  end

  // R4
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));

  // R5
  own_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we && mem_addr == cur |-> !mem_wdata[ACT]);

  // R9
  rx_len_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st == WB1 |-> mem_wdata[15:0] <= mem_wdata[31:16]);

  // R6
  tx_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st == D1 && !rxs && !mem_rdata[ACT] && !tx_go |=> !tx_busy);

  // R10
  rx_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_stop |=> !rx_on);
endmodule

// File: tb/desc_ring_dma_tb.sv
`timescale 1ns/1ps
module desc_ring_dma_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [15:0] tx_base, rx_base, mem_addr;
  logic tx_go, rx_go, rx_stop, tx_busy, rx_on, mem_req, mem_we;
  logic [31:0] mem_wdata, mem_rdata;
  logic tx_valid, tx_last, tx_ready, rx_valid, rx_last, rx_err, rx_ready;
  logic [7:0] tx_data, rx_data;

  desc_ring_dma u_dut (.clk(clk), .rst_n(rst_n), .tx_base(tx_base), .rx_base(rx_base),
    .tx_go(tx_go), .rx_go(rx_go), .rx_stop(rx_stop), .tx_busy(tx_busy), .rx_on(rx_on),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
    .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last),
    .rx_err(rx_err), .rx_ready(rx_ready));

  localparam logic [31:0] ACTB = 32'h8000_0000, EOLB = 32'h4000_0000, ERRB = 32'h0800_0000;

  logic [31:0] mem [256];
  always @(posedge clk)
    if (mem_req) begin
      if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[7:0]];
    end

  int nchk = 0, nerr = 0;
  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic [7:0] txq[$], exq[$];
  bit txl[$], exl[$];
  initial begin
    logic pv, pr, pl;
    logic [7:0] pd;
    pv = 0; pr = 0; pd = 0; pl = 0;
    tx_ready = 0;
    forever begin
      @(negedge clk);
      tx_ready = ($urandom % 4) != 0;
      if (pv && !pr) chk(tx_valid && tx_data == pd && tx_last == pl, "R4", {23'd0, tx_valid, tx_data}, {24'd1, pd});
      if (tx_valid && tx_ready) begin txq.push_back(tx_data); txl.push_back(tx_last); end
      pv = tx_valid; pr = tx_ready; pd = tx_data; pl = tx_last;
    end
  end

  function automatic logic [7:0] bufbyte(input int wa, input int i);
    return 8'(mem[wa + i/4] >> (8*(i%4)));
  endfunction

  task automatic expect_tx(input int wa, input int n);
    for (int i = 0; i < n; i++) begin exq.push_back(bufbyte(wa, i)); exl.push_back(i == n-1); end
  endtask

  task automatic run_tx(input string req);
    @(negedge clk); tx_go = 1; @(negedge clk); tx_go = 0;
    for (int i = 0; i < 5000 && tx_busy; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(txq.size() == exq.size(), req, txq.size(), exq.size());
    for (int i = 0; i < exq.size() && i < txq.size(); i++)
      chk(txq[i] == exq[i] && txl[i] == exl[i], req, {txl[i], txq[i]}, {exl[i], exq[i]});
    txq.delete(); txl.delete(); exq.delete(); exl.delete();
  endtask

  logic [7:0] fb [16];
  task automatic send_frame(input int n, input int errat);
    for (int i = 0; i < n; i++) begin
      bit took;
      rx_valid = 1; rx_data = fb[i]; rx_last = (i == n-1); rx_err = (i == errat);
      do begin took = rx_ready; @(negedge clk); end while (!took);
    end
    rx_valid = 0; rx_last = 0; rx_err = 0;
  endtask

  function automatic logic [31:0] pw(input int k, input int lim);
    logic [31:0] w = 0;
    for (int j = 0; j < 4; j++) if (4*k + j < lim) w[8*j +: 8] = fb[4*k + j];
    return w;
  endfunction

  task automatic wait_rel(input int a);
    for (int i = 0; i < 2000 && mem[a][31]; i++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL R1 watchdog actual=%0d expected=%0d", 0, 1);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    int idx;
    void'($urandom(32'd4242));
    tx_go = 0; rx_go = 0; rx_stop = 0; rx_valid = 0; rx_last = 0; rx_err = 0; rx_data = 0;
    tx_base = 16'h10; rx_base = 16'h60;
    for (int i = 0; i < 256; i++) mem[i] = 32'hDEADBEEF;
    repeat (3) @(negedge clk);
    chk({tx_busy, rx_on, mem_req, tx_valid, rx_ready} == 0, "R1", {tx_busy, rx_on, mem_req, tx_valid, rx_ready}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk({tx_busy, rx_on, mem_req, tx_valid, rx_ready} == 0, "R1", {tx_busy, rx_on, mem_req, tx_valid, rx_ready}, 0);

    // R2 R3: three-descriptor ring, unaligned low bits on the first buffer, zero length in the middle
    mem[8'h10] = ACTB;        mem[8'h11] = {16'd5, 16'd0}; mem[8'h12] = 32'h82;
    mem[8'h13] = ACTB;        mem[8'h14] = 32'd0;          mem[8'h15] = 32'h100;
    mem[8'h16] = ACTB | EOLB; mem[8'h17] = {16'd9, 16'd0}; mem[8'h18] = 32'h100;
    for (int i = 0; i < 2; i++) mem[8'h20 + i] = $urandom;
    for (int i = 0; i < 3; i++) mem[8'h40 + i] = $urandom;
    expect_tx(8'h20, 5); expect_tx(8'h40, 9);
    run_tx("R3");
    // R5
    chk(mem[8'h10] == 0, "R5", mem[8'h10], 0);
    chk(mem[8'h13] == 0, "R5", mem[8'h13], 0);
    chk(mem[8'h16] == EOLB, "R5", mem[8'h16], EOLB);
    // R6
    chk(!tx_busy, "R6", tx_busy, 0);

    // R2 R6: random rounds walking the ring one descriptor at a time
    idx = 0;
    for (int r = 0; r < 7; r++) begin
      int a, n;
      a = 8'h10 + 3*idx;
      n = $urandom % 13;
      for (int i = 0; i < 4; i++) mem[8'h50 + i] = $urandom;
      mem[a] = ACTB | ((idx == 2) ? EOLB : 0);
      mem[a+1] = {16'(n), 16'hABCD};
      mem[a+2] = 32'h140 | ($urandom % 4);
      expect_tx(8'h50, n);
      run_tx("R6");
      chk(mem[a] == ((idx == 2) ? EOLB : 0), "R5", mem[a], (idx == 2) ? EOLB : 0);
      idx = (idx + 1) % 3;
    end

    // R7: receive ring
    mem[8'h60] = ACTB;        mem[8'h61] = {16'd64, 16'd0}; mem[8'h62] = 32'h200;
    mem[8'h63] = ACTB;        mem[8'h64] = {16'd8, 16'd0};  mem[8'h65] = 32'h280;
    mem[8'h66] = ACTB | EOLB; mem[8'h67] = {16'd64, 16'd0}; mem[8'h68] = 32'h300;
    @(negedge clk); rx_go = 1; @(negedge clk); rx_go = 0;
    for (int i = 0; i < 16; i++) fb[i] = 8'($urandom);
    send_frame(7, -1);
    wait_rel(8'h60);
    chk(mem[8'h60] == 0, "R7", mem[8'h60], 0);
    chk(mem[8'h61] == {16'd64, 16'd7}, "R7", mem[8'h61], {16'd64, 16'd7});
    chk(mem[8'h80] == pw(0, 7), "R7", mem[8'h80], pw(0, 7));
    chk(mem[8'h81] == pw(1, 7), "R7", mem[8'h81], pw(1, 7));
    chk(mem[8'h82] == 32'hDEADBEEF, "R7", mem[8'h82], 32'hDEADBEEF);

    // R9: truncation
    for (int i = 0; i < 16; i++) fb[i] = 8'($urandom);
    send_frame(11, -1);
    wait_rel(8'h63);
    chk(mem[8'h63] == ERRB, "R9", mem[8'h63], ERRB);
    chk(mem[8'h64] == {16'd8, 16'd8}, "R9", mem[8'h64], {16'd8, 16'd8});
    chk(mem[8'hA0] == pw(0, 8) && mem[8'hA1] == pw(1, 8), "R9", mem[8'hA1], pw(1, 8));
    chk(mem[8'hA2] == 32'hDEADBEEF, "R9", mem[8'hA2], 32'hDEADBEEF);

    // R8: error marker, end-of-list kept
    for (int i = 0; i < 16; i++) fb[i] = 8'($urandom);
    send_frame(4, 1);
    wait_rel(8'h66);
    chk(mem[8'h66] == (EOLB | ERRB), "R8", mem[8'h66], EOLB | ERRB);
    chk(mem[8'h67] == {16'd64, 16'd4}, "R8", mem[8'h67], {16'd64, 16'd4});
    chk(mem[8'hC0] == pw(0, 4), "R7", mem[8'hC0], pw(0, 4));

    // R6 R2: wrap onto a released descriptor, then resume
    for (int i = 0; i < 16; i++) fb[i] = 8'($urandom);
    fork
      send_frame(5, -1);
      begin
        repeat (40) @(negedge clk);
        chk(!rx_on, "R6", rx_on, 0);
        chk(mem[8'h60] == 0 && mem[8'h61] == {16'd64, 16'd7}, "R6", mem[8'h61], {16'd64, 16'd7});
        mem[8'h60] = ACTB;
        mem[8'h61] = {16'd64, 16'd0};
        rx_go = 1; @(negedge clk); rx_go = 0;
      end
    join
    wait_rel(8'h60);
    chk(mem[8'h61] == {16'd64, 16'd5}, "R2", mem[8'h61], {16'd64, 16'd5});
    chk(mem[8'h80] == pw(0, 5) && mem[8'h81] == pw(1, 5), "R7", mem[8'h81], pw(1, 5));

    // R10
    mem[8'h63] = ACTB;
    rx_stop = 1; @(negedge clk); rx_stop = 0;
    chk(!rx_on, "R10", rx_on, 0);
    begin
      bit seen = 0;
      rx_valid = 1; rx_data = 8'h5A; rx_last = 1;
      repeat (20) begin @(negedge clk); if (rx_ready) seen = 1; end
      rx_valid = 0; rx_last = 0;
      chk(!seen, "R10", seen, 0);
      chk(mem[8'h63] == ACTB, "R10", mem[8'h63], ACTB);
    end

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule